// File: doc/BRIEF.md
# Soft-Start, Soft-Stop and Fault Supervisor

This block decides when the output stage of a phase-shifted bridge converter may switch, and how fast the control level may grow. It takes digital codes for the supply, the reference, the current sense and the error amplifier output, plus one flag that signals an external shutdown request. From these it keeps a soft-start level in an accumulator. The accumulator rises slowly after a start or restart and falls quickly after an overcurrent event. The block also limits the error level to the soft-start level and produces the force-off signal for the output drivers.

Faults are ranked by priority. A supply that is too low is handled first, then a reference fault, then an external shutdown, then overcurrent. An overcurrent event does not latch the converter off. It starts a fast ramp-down of the soft-start level, and once that level is low enough a full soft restart follows. Two further outputs come from the inputs: a light-load blanking flag with hysteresis on the clamped error level, and a cycle-by-cycle pulse-termination flag for peak current limiting. All thresholds and rates are parameters. The level codes use 51 counts per volt.

Top module: `ss_supervisor`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `mode` is LOCK (code 0), `ss_level` is 0, `force_off` is 1 and `blank` is 1.
- R2: Supply lockout has hysteresis. Operation is permitted once `vdd_code` >= 176 has been seen on a clock edge, and is withdrawn once `vdd_code` < 144 has been seen. Codes in between keep the previous decision. The decision takes effect on `mode` one clock later.
- R3: When `ref_code` < 204, or when operation is not permitted under R2, `ss_level` becomes 0 on the next clock edge.
- R4: An external shutdown (`ext_off` = 1) with no higher-priority fault puts `mode` in OFF (code 1) and holds `ss_level` unchanged.
- R5: `cs_code` >= 128 with no higher-priority fault puts `mode` in STOP (code 2). In STOP, each rate tick lowers `ss_level` by 10, saturating at 0.
- R6: STOP is kept while `ss_level` >= 25. Once the level is below 25 and no fault is present, `mode` becomes RUN (code 3). In RUN, each rate tick raises `ss_level` by 1, saturating at 255. A rate tick occurs on every 4th clock edge after reset.
- R7: Fault priority is, from highest to lowest: low supply (LOCK), reference fault (OFF), external shutdown (OFF), overcurrent (STOP).
- R8: `force_off` is 1 in every mode except RUN.
- R9: `ea_clamped` equals the smaller of `ea_code` and `ss_level` at all times.
- R10: `blank` becomes 1 one cycle after `ea_clamped` is < 25. It becomes 0 one cycle after `ea_clamped` is >= 32. Values in between keep its state.
- R11: `pulse_term` is 1 exactly when `cs_code` >= 102. Values from 102 to 127 do not change `mode` or the ramp.
- R12: An overcurrent event while in RUN re-enters STOP, whatever the soft-start level is at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_code | input | 8 | Supply voltage code |
| ref_code | input | 8 | Reference voltage code |
| ext_off | input | 1 | External shutdown request |
| cs_code | input | 8 | Current sense code |
| ea_code | input | 8 | Error amplifier output code |
| ss_level | output | 8 | Soft-start accumulator |
| ea_clamped | output | 8 | Error level limited to the soft-start level |
| mode | output | 2 | 0 LOCK, 1 OFF, 2 STOP, 3 RUN |
| force_off | output | 1 | Output stage forced off |
| blank | output | 1 | Light-load output blanking |
| pulse_term | output | 1 | Terminate the present PWM pulse |

## Verification
A wrong mode register shows at `mode` and `force_off` on the next clock edge. A wrong accumulator update shows on `ss_level` within one rate tick, which is at most four clocks. It shows sooner on `ea_clamped` whenever the error code exceeds the level. A stuck or inverted hysteresis state shows as a `blank` value that differs from the expected one in the cycle after a sweep crosses 25 or 32. A lockout state stuck in the wrong value shows as the wrong `mode` one clock after `vdd_code` crosses 144 or 176. The bench sweeps each input across its thresholds in both directions, and it runs every combination of the four fault sources against a cycle-exact model.

// File: rtl/ss_sup_pkg.sv
package ss_sup_pkg;

    typedef enum logic [1:0] {
        SUP_LOCK = 2'd0,
        SUP_OFF  = 2'd1,
        SUP_STOP = 2'd2,
        SUP_RUN  = 2'd3
    } sup_mode_e;

    // Fault sources, listed from highest to lowest priority.
    typedef struct packed {
        logic uv;
        logic ref_bad;
        logic ext;
        logic oc;
    } fault_vec_t;

    localparam int DEF_CODE_W = 8;

endpackage

// File: rtl/ss_hyst_cmp.sv
module ss_hyst_cmp #(
    parameter int W         = 8,
    parameter int SET_AT    = 32,
    parameter int CLR_BELOW = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] x,
    output logic         q
);
    localparam logic [W-1:0] SET_V = W'(SET_AT);
    localparam logic [W-1:0] CLR_V = W'(CLR_BELOW);

    always_ff @(posedge clk) begin
        if (rst)             q <= 1'b0;
        else if (x >= SET_V) q <= 1'b1;
        else if (x < CLR_V)  q <= 1'b0;
    end
endmodule

// File: rtl/ss_rate_tick.sv
module ss_rate_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst)              cnt <= '0;
                else if (cnt == LAST) cnt <= '0;
                else                  cnt <= cnt + 1'b1;
            end
            assign tick = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
    import ss_sup_pkg::*;
#(
    parameter int W        = 8,
    parameter int SS_LOW   = 25,
    parameter int CHG_STEP = 1,
    parameter int DIS_STEP = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  fault_vec_t   flt,
    input  logic         tick,
    output sup_mode_e    mode_q,
    output logic [W-1:0] level_q
);
    localparam logic [W-1:0] LOW_V = W'(SS_LOW);
    localparam logic [W:0]   CHG_V = (W+1)'(CHG_STEP);
    localparam logic [W-1:0] DIS_V = W'(DIS_STEP);

    sup_mode_e    mode_n;
    logic [W-1:0] level_n;
    logic [W:0]   sum;
    logic [W-1:0] up_v;
    logic [W-1:0] dn_v;

    always_comb begin
        sum  = {1'b0, level_q} + CHG_V;
        up_v = sum[W] ? '1 : sum[W-1:0];
        dn_v = (level_q > DIS_V) ? (level_q - DIS_V) : '0;
    end

    always_comb begin
        mode_n  = mode_q;
        level_n = level_q;
        if (flt.uv) begin
            mode_n  = SUP_LOCK;
            level_n = '0;
        end else if (flt.ref_bad) begin
            mode_n  = SUP_OFF;
            level_n = '0;
        end else if (flt.ext) begin
            mode_n  = SUP_OFF;
        end else if (flt.oc || (mode_q == SUP_STOP && level_q >= LOW_V)) begin
            mode_n = SUP_STOP;
            if (tick) level_n = dn_v;
        end else begin
            mode_n = SUP_RUN;
            if (tick) level_n = up_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= SUP_LOCK;
            level_q <= '0;
        end else begin
            mode_q  <= mode_n;
            level_q <= level_n;
        end
    end
endmodule

// File: rtl/ss_supervisor.sv
module ss_supervisor
    import ss_sup_pkg::*;
#(
    parameter int CODE_W    = DEF_CODE_W,
    parameter int RATE_DIV  = 4,
    parameter int UV_ON     = 176,
    parameter int UV_OFF    = 144,
    parameter int REF_MIN   = 204,
    parameter int SS_LOW    = 25,
    parameter int OC_LIM    = 128,
    parameter int PEAK_LIM  = 102,
    parameter int LOAD_OFF  = 25,
    parameter int LOAD_ON   = 32,
    parameter int CHG_STEP  = 1,
    parameter int STOP_MULT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] vdd_code,
    input  logic [CODE_W-1:0] ref_code,
    input  logic              ext_off,
    input  logic [CODE_W-1:0] cs_code,
    input  logic [CODE_W-1:0] ea_code,
    output logic [CODE_W-1:0] ss_level,
    output logic [CODE_W-1:0] ea_clamped,
    output logic [1:0]        mode,
    output logic              force_off,
    output logic              blank,
    output logic              pulse_term
);
    localparam logic [CODE_W-1:0] REF_V  = CODE_W'(REF_MIN);
    localparam logic [CODE_W-1:0] OC_V   = CODE_W'(OC_LIM);
    localparam logic [CODE_W-1:0] PEAK_V = CODE_W'(PEAK_LIM);
    localparam int                DIS_STEP = CHG_STEP * STOP_MULT;

    logic       uv_ok;
    logic       load_en;
    logic       tick;
    fault_vec_t flt;
    sup_mode_e  mode_q;

    ss_rate_tick #(.DIV(RATE_DIV)) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    ss_hyst_cmp #(.W(CODE_W), .SET_AT(UV_ON), .CLR_BELOW(UV_OFF)) u_uvlo (
        .clk(clk),
        .rst(rst),
        .x  (vdd_code),
        .q  (uv_ok)
    );

    always_comb begin
        flt.uv      = ~uv_ok;
        flt.ref_bad = (ref_code < REF_V);
        flt.ext     = ext_off;
        flt.oc      = (cs_code >= OC_V);
    end

    ss_seq_fsm #(
        .W       (CODE_W),
        .SS_LOW  (SS_LOW),
        .CHG_STEP(CHG_STEP),
        .DIS_STEP(DIS_STEP)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .flt    (flt),
        .tick   (tick),
        .mode_q (mode_q),
        .level_q(ss_level)
    );

    assign ea_clamped = (ea_code < ss_level) ? ea_code : ss_level;

    ss_hyst_cmp #(.W(CODE_W), .SET_AT(LOAD_ON), .CLR_BELOW(LOAD_OFF)) u_load (
        .clk(clk),
        .rst(rst),
        .x  (ea_clamped),
        .q  (load_en)
    );

    assign blank      = ~load_en;
    assign mode       = mode_q;
    assign force_off  = (mode_q != SUP_RUN);
    assign pulse_term = (cs_code >= PEAK_V);
endmodule

// File: rtl/ss_supervisor_chk.sv
module ss_supervisor_chk
    import ss_sup_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int REF_MIN  = 204,
    parameter int SS_LOW   = 25,
    parameter int OC_LIM   = 128,
    parameter int LOAD_OFF = 25,
    parameter int LOAD_ON  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              uv_ok,
    input logic [CODE_W-1:0] ref_code,
    input logic              ext_off,
    input logic [CODE_W-1:0] cs_code,
    input logic [CODE_W-1:0] ea_code,
    input logic [CODE_W-1:0] ss_level,
    input logic [CODE_W-1:0] ea_clamped,
    input logic [1:0]        mode,
    input logic              blank
);
    localparam logic [CODE_W-1:0] REF_V  = CODE_W'(REF_MIN);
    localparam logic [CODE_W-1:0] LOW_V  = CODE_W'(SS_LOW);
    localparam logic [CODE_W-1:0] OC_V   = CODE_W'(OC_LIM);
    localparam logic [CODE_W-1:0] LOFF_V = CODE_W'(LOAD_OFF);
    localparam logic [CODE_W-1:0] LON_V  = CODE_W'(LOAD_ON);

    logic clean;
    assign clean = uv_ok && (ref_code >= REF_V) && !ext_off;

    // R3
    ref_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_code < REF_V) |=> (ss_level == '0));

    // R7
    uv_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !uv_ok |=> (mode == 2'(SUP_LOCK)));

    // R4
    ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (uv_ok && ref_code >= REF_V && ext_off)
        |=> (mode == 2'(SUP_OFF)) && $stable(ss_level));

    // R12
    oc_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (clean && cs_code >= OC_V) |=> (mode == 2'(SUP_STOP)));

    // R5
    stop_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'(SUP_STOP) && ss_level >= LOW_V)
        |=> (ss_level <= $past(ss_level)));

    // R6
    run_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (clean && cs_code < OC_V && mode == 2'(SUP_RUN))
        |=> (ss_level >= $past(ss_level)) && (mode == 2'(SUP_RUN)));

    // R9
    clamp_lim_chk: assert property (@(posedge clk) disable iff (rst)
        (ea_clamped <= ss_level) && (ea_clamped <= ea_code));

    // R10
    blank_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ea_clamped < LOFF_V) |=> blank);

    // R10
    blank_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ea_clamped >= LON_V) |=> !blank);
endmodule

bind ss_supervisor ss_supervisor_chk #(
    .CODE_W  (CODE_W),
    .REF_MIN (REF_MIN),
    .SS_LOW  (SS_LOW),
    .OC_LIM  (OC_LIM),
    .LOAD_OFF(LOAD_OFF),
    .LOAD_ON (LOAD_ON)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .uv_ok     (uv_ok),
    .ref_code  (ref_code),
    .ext_off   (ext_off),
    .cs_code   (cs_code),
    .ea_code   (ea_code),
    .ss_level  (ss_level),
    .ea_clamped(ea_clamped),
    .mode      (mode),
    .blank     (blank)
);

// File: tb/test_ss_supervisor.sv
module test_ss_supervisor;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] vdd_code = 8'd0;
    logic [7:0] ref_code = 8'd0;
    logic       ext_off = 1'b0;
    logic [7:0] cs_code = 8'd0;
    logic [7:0] ea_code = 8'd0;
    logic [7:0] ss_level;
    logic [7:0] ea_clamped;
    logic [1:0] mode;
    logic       force_off;
    logic       blank;
    logic       pulse_term;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state, derived from the requirements
    int m_mode = 0;
    int m_lvl  = 0;
    int m_uv   = 0;
    int m_en   = 0;
    int m_cnt  = 0;

    always #(PERIOD/2) clk = ~clk;

    ss_supervisor i_ss_supervisor (
        .clk(clk), .rst(rst), .vdd_code(vdd_code), .ref_code(ref_code),
        .ext_off(ext_off), .cs_code(cs_code), .ea_code(ea_code),
        .ss_level(ss_level), .ea_clamped(ea_clamped), .mode(mode),
        .force_off(force_off), .blank(blank), .pulse_term(pulse_term)
    );

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    task automatic model_step();
        int tick;
        int eac;
        int n_mode;
        int n_lvl;
        if (rst) begin
            m_mode = 0; m_lvl = 0; m_uv = 0; m_en = 0; m_cnt = 0;
            return;
        end
        tick  = (m_cnt == 3);
        eac   = imin(int'(ea_code), m_lvl);
        n_mode = m_mode;
        n_lvl  = m_lvl;
        if (!m_uv) begin n_mode = 0; n_lvl = 0; end
        else if (ref_code < 204) begin n_mode = 1; n_lvl = 0; end
        else if (ext_off) n_mode = 1;
        else if (cs_code >= 128 || (m_mode == 2 && m_lvl >= 25)) begin
            n_mode = 2;
            if (tick) n_lvl = (m_lvl > 10) ? m_lvl - 10 : 0;
        end else begin
            n_mode = 3;
            if (tick) n_lvl = imin(m_lvl + 1, 255);
        end
        if (vdd_code >= 176) m_uv = 1;
        else if (vdd_code < 144) m_uv = 0;
        if (eac >= 32) m_en = 1;
        else if (eac < 25) m_en = 0;
        m_cnt  = tick ? 0 : m_cnt + 1;
        m_mode = n_mode;
        m_lvl  = n_lvl;
    endtask

    task automatic chk(string ph, string fld, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", ph, fld, got, exp);
        end
    endtask

    task automatic cyc(string ph);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(ph, "mode", int'(mode), m_mode);
        chk(ph, "ss_level", int'(ss_level), m_lvl);
        chk(ph, "force_off (R8)", int'(force_off), (m_mode != 3) ? 1 : 0);
        chk(ph, "ea_clamped (R9)", int'(ea_clamped), imin(int'(ea_code), m_lvl));
        chk(ph, "blank (R10)", int'(blank), m_en ? 0 : 1);
        chk(ph, "pulse_term (R11)", int'(pulse_term), (cs_code >= 102) ? 1 : 0);
    endtask

    task automatic run(string ph, int n);
        for (int i = 0; i < n; i++) cyc(ph);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        run("R1 reset", 3);
        rst = 1'b0;
        cyc("R1 first cycle after reset");
        ref_code = 8'd255;
        ea_code  = 8'd200;
        // R2 lockout hysteresis: sweep up then down, then back up
        for (int v = 0; v < 256; v += 4) begin
            vdd_code = 8'(v);
            run("R2 supply rising", 2);
        end
        for (int v = 252; v >= 0; v -= 4) begin
            vdd_code = 8'(v);
            run("R2 supply falling", 2);
        end
        vdd_code = 8'd160;
        run("R2 inside band stays locked", 6);
        vdd_code = 8'd200;
        run("R6 ramp to full scale", 1100);
        for (int c = 0; c < 128; c++) begin
            cs_code = 8'(c);
            cyc("R11 peak limit sweep");
        end
        cs_code = 8'd130;
        cyc("R5 overcurrent entry");
        cs_code = 8'd0;
        run("R5 soft-stop ramp down", 120);
        run("R6 soft restart", 150);
        cs_code = 8'd200;
        cyc("R12 overcurrent during ramp");
        cs_code = 8'd0;
        run("R12 stop and restart", 200);
        ext_off = 1'b1;
        run("R4 external shutdown", 20);
        ext_off = 1'b0;
        run("R4 release", 30);
        ref_code = 8'd100;
        run("R3 reference fault", 10);
        ref_code = 8'd255;
        run("R3 reference recovered", 40);
        for (int f = 0; f < 16; f++) begin
            vdd_code = f[0] ? 8'd100 : 8'd200;
            ref_code = f[1] ? 8'd100 : 8'd255;
            ext_off  = f[2];
            cs_code  = f[3] ? 8'd140 : 8'd0;
            run("R7 R8 fault priority", 6);
            vdd_code = 8'd200; ref_code = 8'd255; ext_off = 1'b0; cs_code = 8'd0;
            run("R7 recover", 8);
        end
        run("R6 ramp to full scale again", 1100);
        for (int e = 0; e < 256; e++) begin
            ea_code = 8'(e);
            cyc("R9 R10 error rising");
        end
        for (int e = 255; e >= 0; e--) begin
            ea_code = 8'(e);
            cyc("R9 R10 error falling");
        end
        finish_run();
    end
endmodule